// File: doc/BRIEF.md
# LIN Frame Receive Checker

This block sits behind a LIN byte receiver and judges each incoming frame. It consumes a stream of already deserialized bytes, framed by a start-of-frame strobe and an end-of-frame strobe. The first byte after the start strobe is the protected identifier. It is followed by the data bytes and then one checksum byte.

The checker recomputes the two identifier parity bits. When they disagree with the received bits, the command is dropped: no command pulse is issued and the rest of the frame is discarded. When the parity is good, the identifier is announced. The data bytes are summed with end-around carry, and the inverted result is compared against the checksum byte. A frame whose data ends early is reported as a framing fault. A frame that passes every check produces a single valid pulse when it ends.

Faults are kept in three sticky flags that a host clears with a pulse. An aggregate response-error bit has its own clear, so a slave can report that an error has occurred in a later response.

Top module: `lin_frame_guard`

## Requirements
- R1: The identifier byte holds the identifier in bits 5:0, parity bit P0 in bit 6 and P1 in bit 7, where P0 = ID0^ID1^ID2^ID4 and P1 = ~(ID1^ID3^ID4^ID5). When both parity bits match, `cmd_vld` is high for exactly the one cycle after the clock edge that took in the identifier byte, and `cmd_id` shows bits 5:0 of that byte.
- R2: When either identifier parity bit mismatches, `par_err` is set one cycle after that byte. No `cmd_vld` is issued, no `frame_ok` is issued, and the remaining bytes and the end strobe of that frame raise no other flag.
- R3: The expected checksum is the bitwise inverse of the 8-bit sum of the data bytes, with each carry out of bit 7 added back into bit 0. A received checksum byte that differs from it sets `cks_err`.
- R4: The data length is taken from `cfg_len` in the start-strobe cycle. A value of 0 counts as 1 and a value above 8 counts as 8. The byte that follows that many data bytes is the checksum, and any bytes after it are ignored.
- R5: An end strobe that arrives after a good identifier but before the checksum byte sets `frm_err`.
- R6: `frame_ok` is high for one cycle after the end strobe only if the identifier parity passed and the checksum byte matched.
- R7: The three error flags stay set until `clr_errs` is pulsed. A new error in the same cycle as `clr_errs` leaves its flag set.
- R8: `resp_err` is set by any parity, checksum or framing error. Only `clr_resp` clears it, and a new error in the same cycle as `clr_resp` leaves it set.
- R9: After reset, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_vld | input | 1 | Received byte valid |
| rx_byte | input | 8 | Received byte |
| rx_sof | input | 1 | Start-of-frame strobe, sent in its own cycle |
| rx_eof | input | 1 | End-of-frame strobe, sent in its own cycle |
| cfg_len | input | 4 | Number of data bytes, 1 to 8 |
| clr_errs | input | 1 | Clears the three error flags |
| clr_resp | input | 1 | Clears the response-error bit |
| cmd_vld | output | 1 | Identifier accepted pulse |
| cmd_id | output | 6 | Accepted identifier |
| frame_ok | output | 1 | Clean frame pulse |
| par_err | output | 1 | Sticky identifier parity error |
| cks_err | output | 1 | Sticky checksum error |
| frm_err | output | 1 | Sticky framing error |
| resp_err | output | 1 | Sticky response-error status |

## Verification
A corrupted running sum or a lost state in the frame sequencer shows up at the end of the same frame. It appears either as a missing `frame_ok` or as a spurious `cks_err` or `frm_err`, visible one cycle after the end strobe. A wrong byte count shifts which byte is taken as the checksum, so it also shows up within that frame. A bad parity decision is visible one cycle after the identifier byte, through `cmd_vld` or `par_err`. Flag retention faults are exposed by checking the flags after every frame against a running model that includes randomly placed clears.

// File: rtl/lin_chk_pkg.sv
package lin_chk_pkg;

    typedef enum logic [2:0] {
        S_IDLE = 3'd0,
        S_ID   = 3'd1,
        S_DATA = 3'd2,
        S_CKS  = 3'd3,
        S_DONE = 3'd4,
        S_DROP = 3'd5
    } fsm_e;

    // error event slot positions
    localparam int EV_PAR = 0;
    localparam int EV_CKS = 1;
    localparam int EV_FRM = 2;
    localparam int EV_NUM = 3;

    typedef struct packed {
        logic [1:0] par;   // {P1, P0}
        logic [5:0] id;
    } id_byte_t;

    function automatic logic [1:0] id_parity(input logic [5:0] id);
        logic p0, p1;
        p0 = id[0] ^ id[1] ^ id[2] ^ id[4];
        p1 = ~(id[1] ^ id[3] ^ id[4] ^ id[5]);
        return {p1, p0};
    endfunction

    function automatic logic [7:0] sum_wrap(input logic [7:0] acc, input logic [7:0] b);
        logic [8:0] s;
        s = {1'b0, acc} + {1'b0, b};
        return s[7:0] + {7'd0, s[8]};
    endfunction

endpackage

// File: rtl/lin_id_check.sv
module lin_id_check
    import lin_chk_pkg::*;
(
    input  logic [7:0] id_raw,
    output logic       id_good,
    output logic [5:0] id_val
);
    id_byte_t ib;
    logic [1:0] want;

    always_comb begin
        ib      = id_byte_t'(id_raw);
        want    = id_parity(ib.id);
        id_good = (want == ib.par);
        id_val  = ib.id;
    end
endmodule

// File: rtl/lin_cks_acc.sv
module lin_cks_acc
    import lin_chk_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clear,
    input  logic          add_en,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] cks_exp
);
    logic [DW-1:0] acc_q;

    always_ff @(posedge clk) begin
        if (rst || clear) acc_q <= '0;
        else if (add_en)  acc_q <= sum_wrap(acc_q, din);
    end

    assign cks_exp = ~acc_q;
endmodule

// File: rtl/lin_err_flags.sv
module lin_err_flags #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] evt,
    input  logic         clr,
    input  logic         resp_clr,
    output logic [N-1:0] flags,
    output logic         resp
);
    for (genvar g = 0; g < N; g++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst)         flags[g] <= 1'b0;
            else if (evt[g]) flags[g] <= 1'b1;
            else if (clr)    flags[g] <= 1'b0;
        end

        AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (rst)
            flags[g] && !clr |=> flags[g]); // R7
        AST_FLAG_SET_WINS: assert property (@(posedge clk) disable iff (rst)
            evt[g] |=> flags[g]); // R7
        AST_FLAG_CLEARS: assert property (@(posedge clk) disable iff (rst)
            clr && !evt[g] |=> !flags[g]); // R7
    end

    always_ff @(posedge clk) begin
        if (rst)           resp <= 1'b0;
        else if (|evt)     resp <= 1'b1;
        else if (resp_clr) resp <= 1'b0;
    end

    AST_RESP_ON_ERR: assert property (@(posedge clk) disable iff (rst)
        (|evt) |=> resp); // R8
    AST_RESP_HOLD: assert property (@(posedge clk) disable iff (rst)
        resp && !resp_clr |=> resp); // R8
    AST_ONE_EVT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(evt)); // R2
endmodule

// File: rtl/lin_frame_guard.sv
module lin_frame_guard
    import lin_chk_pkg::*;
#(
    parameter int MAX_DATA = 8,
    parameter int LEN_W    = $clog2(MAX_DATA + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rx_vld,
    input  logic [7:0]       rx_byte,
    input  logic             rx_sof,
    input  logic             rx_eof,
    input  logic [LEN_W-1:0] cfg_len,
    input  logic             clr_errs,
    input  logic             clr_resp,
    output logic             cmd_vld,
    output logic [5:0]       cmd_id,
    output logic             frame_ok,
    output logic             par_err,
    output logic             cks_err,
    output logic             frm_err,
    output logic             resp_err
);
    localparam logic [LEN_W-1:0] LEN_MAX = LEN_W'(MAX_DATA);
    localparam logic [LEN_W-1:0] ONE     = LEN_W'(1);

    fsm_e             st_q, st_d;
    logic [LEN_W-1:0] cnt_q, cnt_d, len_q, len_d;
    logic             good_q, good_d;
    logic [EV_NUM-1:0] evt;
    logic             cmd_pulse, ok_pulse, acc_clr, acc_add;
    logic             id_good;
    logic [5:0]       id_val;
    logic [7:0]       cks_exp;
    logic [EV_NUM-1:0] flags;

    lin_id_check u_id (
        .id_raw (rx_byte),
        .id_good(id_good),
        .id_val (id_val)
    );

    lin_cks_acc #(.DW(8)) u_acc (
        .clk    (clk),
        .rst    (rst),
        .clear  (acc_clr),
        .add_en (acc_add),
        .din    (rx_byte),
        .cks_exp(cks_exp)
    );

    lin_err_flags #(.N(EV_NUM)) u_flags (
        .clk     (clk),
        .rst     (rst),
        .evt     (evt),
        .clr     (clr_errs),
        .resp_clr(clr_resp),
        .flags   (flags),
        .resp    (resp_err)
    );

    always_comb begin
        st_d      = st_q;
        cnt_d     = cnt_q;
        len_d     = len_q;
        good_d    = good_q;
        evt       = '0;
        cmd_pulse = 1'b0;
        ok_pulse  = 1'b0;
        acc_clr   = 1'b0;
        acc_add   = 1'b0;
        if (rx_sof) begin
            st_d    = S_ID;
            cnt_d   = '0;
            good_d  = 1'b0;
            acc_clr = 1'b1;
            if (cfg_len == '0)          len_d = ONE;
            else if (cfg_len > LEN_MAX) len_d = LEN_MAX;
            else                        len_d = cfg_len;
        end else if (rx_eof) begin
            case (st_q)
                S_ID, S_DATA, S_CKS: evt[EV_FRM] = 1'b1;
                S_DONE:              ok_pulse = good_q;
                default: ;
            endcase
            st_d = S_IDLE;
        end else if (rx_vld) begin
            case (st_q)
                S_ID: begin
                    if (id_good) begin
                        cmd_pulse = 1'b1;
                        st_d      = S_DATA;
                    end else begin
                        evt[EV_PAR] = 1'b1;
                        st_d        = S_DROP;
                    end
                end
                S_DATA: begin
                    acc_add = 1'b1;
                    cnt_d   = cnt_q + ONE;
                    if (cnt_q + ONE == len_q) st_d = S_CKS;
                end
                S_CKS: begin
                    if (rx_byte == cks_exp) good_d = 1'b1;
                    else                    evt[EV_CKS] = 1'b1;
                    st_d = S_DONE;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= S_IDLE;
            cnt_q    <= '0;
            len_q    <= ONE;
            good_q   <= 1'b0;
            cmd_vld  <= 1'b0;
            cmd_id   <= '0;
            frame_ok <= 1'b0;
        end else begin
            st_q     <= st_d;
            cnt_q    <= cnt_d;
            len_q    <= len_d;
            good_q   <= good_d;
            cmd_vld  <= cmd_pulse;
            frame_ok <= ok_pulse;
            if (cmd_pulse) cmd_id <= id_val;
        end
    end

    assign par_err = flags[EV_PAR];
    assign cks_err = flags[EV_CKS];
    assign frm_err = flags[EV_FRM];

    AST_CMD_AFTER_ID: assert property (@(posedge clk) disable iff (rst)
        cmd_vld |-> st_q == S_DATA); // R1
    AST_DROP_SILENT: assert property (@(posedge clk) disable iff (rst)
        st_q == S_DROP |-> !cmd_vld && !frame_ok); // R2
    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= len_q && len_q <= LEN_MAX && len_q != '0); // R4
    AST_OK_FROM_DONE: assert property (@(posedge clk) disable iff (rst)
        frame_ok |-> $past(st_q) == S_DONE && $past(good_q)); // R6
endmodule

// File: tb/lin_frame_guard_tb.sv
`timescale 1ns/1ps
module lin_frame_guard_tb;
    logic       clk = 1'b0;
    logic       rst;
    logic       rx_vld, rx_sof, rx_eof, clr_errs, clr_resp;
    logic [7:0] rx_byte;
    logic [3:0] cfg_len;
    logic       cmd_vld, frame_ok, par_err, cks_err, frm_err, resp_err;
    logic [5:0] cmd_id;

    int n_chk = 0, n_bad = 0;
    bit e_par, e_cks, e_frm, e_resp;

    always #2 clk = ~clk;

    lin_frame_guard u_dut (
        .clk(clk), .rst(rst), .rx_vld(rx_vld), .rx_byte(rx_byte),
        .rx_sof(rx_sof), .rx_eof(rx_eof), .cfg_len(cfg_len),
        .clr_errs(clr_errs), .clr_resp(clr_resp), .cmd_vld(cmd_vld),
        .cmd_id(cmd_id), .frame_ok(frame_ok), .par_err(par_err),
        .cks_err(cks_err), .frm_err(frm_err), .resp_err(resp_err)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] ref_id(input logic [5:0] id, input bit bad);
        logic p0, p1;
        p0 = id[0] ^ id[1] ^ id[2] ^ id[4];
        p1 = !(id[1] ^ id[3] ^ id[4] ^ id[5]);
        return {p1, p0 ^ bad, id};
    endfunction

    function automatic logic [7:0] ref_cks(input logic [7:0] d [8], input int n);
        int s = 0;
        for (int i = 0; i < n; i++) begin
            s = s + d[i];
            if (s > 255) s = s - 255;
        end
        return ~(s[7:0]);
    endfunction

    task automatic step();
        @(negedge clk);
        rx_vld = 0; rx_sof = 0; rx_eof = 0; clr_errs = 0; clr_resp = 0;
    endtask

    task automatic check_flags(input string tag);
        chk({tag, " R7 par_err"}, {7'd0, par_err}, {7'd0, e_par});
        chk({tag, " R3 cks_err"}, {7'd0, cks_err}, {7'd0, e_cks});
        chk({tag, " R5 frm_err"}, {7'd0, frm_err}, {7'd0, e_frm});
        chk({tag, " R8 resp_err"}, {7'd0, resp_err}, {7'd0, e_resp});
    endtask

    // kind: 0 clean, 1 bad parity, 2 bad checksum, 3 truncated
    task automatic frame(input logic [5:0] id, input logic [3:0] len, input int kind,
                         input int extra, input bit clr_at_id);
        logic [7:0] d [8];
        int eff, cut;
        eff = (len == 0) ? 1 : (len > 8 ? 8 : int'(len));
        cut = (kind == 3) ? int'($urandom_range(eff - 1, 0)) : eff;
        for (int i = 0; i < 8; i++) d[i] = 8'($urandom);
        rx_sof = 1; cfg_len = len;
        step();
        rx_vld = 1; rx_byte = ref_id(id, kind == 1); clr_errs = clr_at_id;
        step();
        if (clr_at_id) begin e_cks = 0; e_frm = 0; end
        if (kind == 1) begin
            e_par = 1; e_resp = 1;
            chk("R2 no cmd on bad parity", {7'd0, cmd_vld}, 8'd0);
            chk("R2 par_err set", {7'd0, par_err}, 8'd1);
        end else begin
            chk("R1 cmd_vld", {7'd0, cmd_vld}, 8'd1);
            chk("R1 cmd_id", {2'd0, cmd_id}, {2'd0, id});
        end
        for (int i = 0; i < cut; i++) begin
            rx_vld = 1; rx_byte = d[i];
            step();
            if (i == 0 && kind != 1) chk("R1 cmd_vld one cycle", {7'd0, cmd_vld}, 8'd0);
        end
        if (kind != 3) begin
            rx_vld = 1;
            rx_byte = ref_cks(d, eff) ^ ((kind == 2) ? 8'($urandom_range(255, 1)) : 8'd0);
            step();
            for (int i = 0; i < extra; i++) begin
                rx_vld = 1; rx_byte = 8'($urandom);
                step();
            end
        end
        if (kind == 2) begin e_cks = 1; e_resp = 1; end
        if (kind == 3) begin e_frm = 1; e_resp = 1; end
        rx_eof = 1;
        step();
        chk("R6 frame_ok", {7'd0, frame_ok}, {7'd0, (kind == 0)});
        check_flags("frame");
        step();
        chk("R6 frame_ok one cycle", {7'd0, frame_ok}, 8'd0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h1F2E3D4C));
        rst = 1; rx_vld = 0; rx_sof = 0; rx_eof = 0; clr_errs = 0; clr_resp = 0;
        rx_byte = 0; cfg_len = 4'd8;
        repeat (3) @(negedge clk);
        rst = 0;
        step();
        chk("R9 cmd_vld reset", {7'd0, cmd_vld}, 8'd0);
        chk("R9 cmd_id reset", {2'd0, cmd_id}, 8'd0);
        chk("R9 frame_ok reset", {7'd0, frame_ok}, 8'd0);
        check_flags("R9 reset");

        // directed
        frame(6'h3C, 4'd8, 0, 0, 0);   // R1 R6 clean, full length
        frame(6'h00, 4'd0, 0, 0, 0);   // R4 length 0 acts as 1
        frame(6'h15, 4'd15, 0, 0, 0);  // R4 length above 8 acts as 8
        frame(6'h2A, 4'd3, 0, 3, 0);   // R4 trailing bytes ignored
        frame(6'h01, 4'd4, 1, 0, 0);   // R2 dropped frame
        frame(6'h07, 4'd2, 2, 0, 0);   // R3 bad checksum
        frame(6'h11, 4'd5, 3, 0, 0);   // R5 early end
        // R8 resp_err survives clr_errs; R7 flags survive clr_resp
        clr_errs = 1; step();
        e_par = 0; e_cks = 0; e_frm = 0;
        check_flags("R8 clr_errs only");
        clr_resp = 1; e_par = 1; e_resp = 1;
        rx_sof = 1; cfg_len = 4'd1; step();
        // R7 R8 error coincident with clear: keep flags set
        rx_vld = 1; rx_byte = ref_id(6'h09, 1); clr_errs = 1; clr_resp = 1;
        step();
        check_flags("R7 set wins over clear");
        rx_eof = 1; step();
        check_flags("R2 dropped end silent");
        clr_resp = 1; step(); e_resp = 0;
        check_flags("R8 clr_resp only");
        frame(6'h2F, 4'd6, 1, 0, 1);   // R7 clear in same cycle as parity error

        // random mix
        for (int n = 0; n < 120; n++) begin
            int k;
            k = ($urandom_range(3, 0) == 0) ? int'($urandom_range(3, 1)) : 0;
            frame(6'($urandom), 4'($urandom_range(15, 0)), k,
                  int'($urandom_range(2, 0)), 1'b0);
            if ($urandom_range(4, 0) == 0) begin
                clr_errs = 1; step(); e_par = 0; e_cks = 0; e_frm = 0;
                check_flags("R7 random clear");
            end
            if ($urandom_range(4, 0) == 0) begin
                clr_resp = 1; step(); e_resp = 0;
                check_flags("R8 random clear");
            end
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule